// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and reports the most urgent pending line to a processor. Each line carries a 4-bit urgency value and an enable bit. Software sets and clears an enable bit by writing the line's number, not a bitmask. A threshold register holds back every line whose urgency is not strictly above the threshold. One output, `irq_o`, tells the processor that something can be serviced.

The processor runs the block through a plain 32-bit, word-addressed register port. Writes take effect on the clock edge on which `bus_wr` is sampled. A read presented with `bus_rd` returns its word on `bus_rdata` one cycle later, with `bus_rvalid` high for that cycle. The port has no back-pressure: every access is accepted on the cycle it is presented.

The vector word packs the winning line number into the upper half and its urgency into the lower half. When nothing is eligible the word reads as all ones, which is negative as a signed value, so a service loop can stop on a sign test.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every enable bit is clear, every urgency field is zero, the threshold register reads 0x10, `irq_o` is low, and the vector word reads 0xFFFFFFFF.
- R2: A write of a value n below 64 to the enable-by-number register (word 1) sets only line n's enable bit. A written value of 64 or more has no effect.
- R3: A write of a value n below 64 to the disable-by-number register (word 2) clears only line n's enable bit. A written value of 64 or more has no effect.
- R4: Line n's urgency field sits in bits [(n mod 8)*4+3 : (n mod 8)*4] of urgency word 11 - (n div 8). Lines 0–7 are in word 11 and lines 56–63 are in word 4. Urgency words read back the value last written.
- R5: When a line is eligible, a read of the vector word (word 3) returns the winning line number in bits [31:16] and its urgency, zero-extended, in bits [15:0].
- R6: When no line is eligible, the vector word reads 0xFFFFFFFF.
- R7: The threshold register (word 0) is 5 bits wide and reads back the last value written. When bit 4 is set, no line is held back. Otherwise a line takes part only if its urgency is strictly greater than bits [3:0].
- R8: Among eligible lines, the highest urgency wins. When urgencies are equal, the higher line number wins.
- R9: A line is eligible only while its input is high, it is enabled and it passes the threshold. Nothing is latched, so lowering the input removes the line at once.
- R10: `irq_o` is high exactly when the vector word would read non-negative.
- R11: Every read returns its data in the next cycle with `bus_rvalid` high. Reads of words 1, 2 and 12–15 return zero. Writes to words 3 and 12–15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| bus_rvalid | output | 1 | High for the cycle that carries read data |
| src_in | input | 64 | Level-sensitive interrupt lines |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong enable bit or urgency field shows up at the port on the next vector read: the wrong line wins, or a valid line hides behind an all-ones word. `irq_o` shows the same fault in the same cycle, because it is combinational from the stored state and the input lines. A wrong comparison in the arbitration tree shows up only when two eligible lines have equal or adjacent urgency, so ties, threshold edges and the top line number each get a directed case. A threshold register that decodes the wrong bits shows as a wrong read-back one cycle after the read.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned GROUP_SZ  = 8;
  localparam logic [ADDR_W-1:0] A_LEVEL = 4'd0;
  localparam logic [ADDR_W-1:0] A_ENNUM = 4'd1;
  localparam logic [ADDR_W-1:0] A_DISNUM = 4'd2;
  localparam logic [ADDR_W-1:0] A_VECTOR = 4'd3;
  localparam int unsigned PRIO_LO   = 4;   // lowest urgency word
  localparam int unsigned PRIO_HI   = 11;  // highest urgency word (lines 0..7)
  localparam logic [BUS_W-1:0] VEC_NONE = '1;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BUS_W-1:0]         wdata,
  output logic [NUM_SRC-1:0]       en_q,
  output logic [PRIO_W-1:0]        prio_q [NUM_SRC],
  output logic [PRIO_W:0]          lvl_q
);
  localparam int unsigned NGRP = NUM_SRC / GROUP_SZ;

  logic num_ok;
  assign num_ok = (wdata < BUS_W'(NUM_SRC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= {1'b1, {PRIO_W{1'b0}}};
    else if (wr && addr == A_LEVEL) lvl_q <= wdata[PRIO_W:0];
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int unsigned GRP_ADDR = PRIO_HI - (s / GROUP_SZ);
    localparam int unsigned LSB      = (s % GROUP_SZ) * PRIO_W;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[s]   <= 1'b0;
        prio_q[s] <= '0;
      end else if (wr) begin
        if (addr == A_ENNUM && num_ok && wdata == BUS_W'(s))
          en_q[s] <= 1'b1;
        if (addr == A_DISNUM && num_ok && wdata == BUS_W'(s))
          en_q[s] <= 1'b0;
        if (addr == ADDR_W'(GRP_ADDR))
          prio_q[s] <= wdata[LSB +: PRIO_W];
      end
    end
  end

  if (PRIO_HI - PRIO_LO + 1 != NGRP) begin : g_bad_cfg
    initial $error("urgency word count does not match source count");
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic [NUM_SRC-1:0]         elig,
  input  logic [PRIO_W-1:0]          prio [NUM_SRC],
  output logic                       win_valid,
  output logic [$clog2(NUM_SRC)-1:0] win_idx,
  output logic [PRIO_W-1:0]          win_prio
);
  localparam int unsigned IDX_W  = $clog2(NUM_SRC);
  localparam int unsigned LEAVES = 1 << IDX_W;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  typedef struct packed {
    logic              v;
    logic [PRIO_W-1:0] p;
    logic [IDX_W-1:0]  i;
  } node_t;

  node_t node [NODES];

  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    if (l < NUM_SRC) begin : g_real
      assign node[LEAVES-1+l] = '{v: elig[l], p: prio[l], i: IDX_W'(l)};
    end else begin : g_pad
      assign node[LEAVES-1+l] = '{v: 1'b0, p: '0, i: IDX_W'(l)};
    end
  end

  // right child covers higher line numbers: it wins ties
  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    node_t lo, hi;
    assign lo = node[2*k+1];
    assign hi = node[2*k+2];
    assign node[k] = (hi.v && (!lo.v || hi.p >= lo.p)) ? hi : lo;
  end

  assign win_valid = node[0].v;
  assign win_idx   = node[0].i;
  assign win_prio  = node[0].p;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [NUM_SRC-1:0] src_in,
  output logic              irq_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);
  localparam int unsigned HALF  = BUS_W / 2;

  logic [NUM_SRC-1:0] en_q;
  logic [PRIO_W-1:0]  prio_q [NUM_SRC];
  logic [PRIO_W:0]    lvl_q;
  logic [NUM_SRC-1:0] elig;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic [PRIO_W-1:0]  win_prio;
  logic [BUS_W-1:0]   vec_word;
  logic [BUS_W-1:0]   rd_mux;

  prio_irq_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .en_q(en_q), .prio_q(prio_q), .lvl_q(lvl_q)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_elig
    assign elig[s] = src_in[s] && en_q[s] &&
                     (lvl_q[PRIO_W] || (prio_q[s] > lvl_q[PRIO_W-1:0]));
  end

  prio_irq_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .elig(elig), .prio(prio_q), .win_valid(win_valid),
    .win_idx(win_idx), .win_prio(win_prio)
  );

  assign vec_word = win_valid ? {HALF'(win_idx), HALF'(win_prio)} : VEC_NONE;
  assign irq_o    = win_valid;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_LEVEL) rd_mux = BUS_W'(lvl_q);
    else if (bus_addr == A_VECTOR) rd_mux = vec_word;
    else if (bus_addr >= ADDR_W'(PRIO_LO) && bus_addr <= ADDR_W'(PRIO_HI)) begin
      for (int j = 0; j < GROUP_SZ; j++)
        rd_mux[j*PRIO_W +: PRIO_W] =
          prio_q[(PRIO_HI - int'(bus_addr)) * GROUP_SZ + j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int unsigned NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rd,
  input logic [3:0]         bus_addr,
  input logic [31:0]        bus_rdata,
  input logic               bus_rvalid,
  input logic [NUM_SRC-1:0] src_in,
  input logic               irq_o
);
  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  assert_idle_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  assert_hole_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr >= 4'd12 || bus_addr == 4'd1 || bus_addr == 4'd2))
      |=> bus_rdata == 32'd0);
  assert_vector_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'd3) |=> (bus_rdata[31] == !$past(irq_o)));
  assert_vector_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'd3 && irq_o) |=>
      (bus_rdata[15:4] == 12'd0 && bus_rdata[31:16] < 16'(NUM_SRC)));
  assert_quiet_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_in == '0) |-> !irq_o);
  assert_level_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'd0) |=> bus_rdata[31:5] == 27'd0);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .src_in(src_in), .irq_o(irq_o)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [63:0] src_in = '0;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [63:0] m_en = '0;
  logic [3:0]  m_prio [64];
  logic [4:0]  m_lvl = 5'h10;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .src_in(src_in), .irq_o(irq_o)
  );

  function automatic logic [31:0] model_vec();
    int best = -1;
    for (int i = 0; i < 64; i++)
      if (src_in[i] && m_en[i] && (m_lvl[4] || m_prio[i] > m_lvl[3:0]))
        if (best < 0 || m_prio[i] >= m_prio[best]) best = i;
    return (best < 0) ? 32'hFFFF_FFFF : {16'(best), 12'd0, m_prio[best]};
  endfunction

  function automatic logic [31:0] model_grp(int a);
    logic [31:0] w = '0;
    for (int j = 0; j < 8; j++) w[j*4 +: 4] = m_prio[(11 - a) * 8 + j];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    if (a == 4'd0) m_lvl = d[4:0];
    else if (a == 4'd1 && d < 64) m_en[d] = 1'b1;
    else if (a == 4'd2 && d < 64) m_en[d] = 1'b0;
    else if (a >= 4'd4 && a <= 4'd11)
      for (int j = 0; j < 8; j++) m_prio[(11 - a) * 8 + j] = d[j*4 +: 4];
  endtask

  // driver: present a read and queue its expected word
  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic set_prio(int s, logic [3:0] p);
    logic [31:0] w;
    int a = 11 - s / 8;
    w = model_grp(a);
    w[(s % 8) * 4 +: 4] = p;
    wr(4'(a), w);
  endtask

  task automatic vec(string tag);
    rd(4'd3, model_vec(), tag);
    check({tag, " irq"}, 32'(irq_o), 32'(model_vec() != 32'hFFFF_FFFF));
  endtask

  // monitor: pop and compare on every returned read
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R11 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_prio[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    src_in = '1;
    // R1 reset state
    rd(4'd0, 32'h10, "R1 level reset");
    rd(4'd7, 32'h0, "R1 urgency reset");
    vec("R1 vector reset");
    rd(4'd3, 32'hFFFF_FFFF, "R6 nothing eligible");
    src_in = '0;
    // R2 R4 R5 single line
    set_prio(5, 4'd3);
    rd(4'd11, 32'h0030_0000, "R4 line 5 field");
    wr(4'd1, 32'd5);
    src_in[5] = 1;
    rd(4'd3, 32'h0005_0003, "R5 vector packing");
    vec("R2 enable line 5");
    // R8 higher urgency and tie
    set_prio(12, 4'd7); wr(4'd1, 32'd12); src_in[12] = 1;
    vec("R8 higher urgency wins");
    set_prio(40, 4'd7); wr(4'd1, 32'd40); src_in[40] = 1;
    rd(4'd3, 32'h0028_0007, "R8 tie to higher number");
    // R4 top line in lowest word
    set_prio(63, 4'd2); wr(4'd1, 32'd63); src_in[63] = 1;
    rd(4'd4, 32'h2000_0000, "R4 line 63 field");
    vec("R8 lower urgency high number loses");
    // R7 threshold
    wr(4'd0, 32'd7);
    rd(4'd0, 32'd7, "R7 threshold readback");
    rd(4'd3, 32'hFFFF_FFFF, "R7 equal urgency held back");
    check("R10 irq low when masked", 32'(irq_o), 32'd0);
    wr(4'd0, 32'd6);
    rd(4'd3, 32'h0028_0007, "R7 strictly above passes");
    wr(4'd0, 32'd2);
    vec("R7 low threshold drops line 63");
    wr(4'd0, 32'h10);
    // R3 and out-of-range numbers
    wr(4'd2, 32'd40);
    rd(4'd3, 32'h000C_0007, "R3 disable line 40");
    wr(4'd1, 32'd104);
    rd(4'd3, 32'h000C_0007, "R2 number 104 ignored");
    wr(4'd2, 32'd76);
    rd(4'd3, 32'h000C_0007, "R3 number 76 ignored");
    // R9 level sensitivity
    src_in[12] = 0;
    @(negedge clk);
    rd(4'd3, 32'h0005_0003, "R9 dropped line leaves");
    src_in = '0;
    @(negedge clk);
    check("R10 irq low with idle lines", 32'(irq_o), 32'd0);
    // R11 holes
    wr(4'd13, 32'hFFFF_FFFF);
    wr(4'd3, 32'h1234_5678);
    rd(4'd13, 32'd0, "R11 hole reads zero");
    rd(4'd1, 32'd0, "R11 enable word reads zero");
    src_in[5] = 1;
    vec("R11 vector write ignored");
    for (int a = 4; a <= 11; a++) rd(4'(a), model_grp(a), "R11 urgency words untouched");
    repeat (3) @(negedge clk);
    check("R11 reads all returned", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule